// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Non-Maskable Source

This block gathers interrupt requests from 29 internal sources, 8 external pins, one non-maskable internal source and a software request port. It latches each request as a pending bit, gates pending maskable sources with a per-source enable, and picks a single winner to present to the processor as a 7-bit vector number together with the service level that the processor enters when it accepts the request. Every maskable source carries a 2-bit priority. External pins pass through a per-pin edge detector that can react to a rising edge, a falling edge or both, or be switched off. Each pin can also be filtered by a slow sample tick.

The processor accepts the presented request with `ack`. This clears the request's pending bit, saves the current service level on an internal stack and enters the new level. `ret` restores the saved level. Nesting therefore works naturally: a request interrupts the running handler only if its level is strictly above the level in service. The non-maskable source and software requests bypass that rule.

Top module: `irq_ctrl`

## Requirements
- R1: After reset no request is pending, `irq_valid` is 0 and `svc_lvl` is 0. Whenever `irq_valid` is 0, `irq_vec` and `irq_lvl` read 0.
- R2: A high `int_req[i]` at a clock edge latches source i as pending whether or not it is enabled. A disabled pending source is never presented. Once enabled, it is presented with vector i+1. External pin k is source 29+k.
- R3: Among pending enabled sources, the highest 2-bit level wins. On equal levels the lower source index wins. A maskable winner of level L is presented with `irq_lvl` = L+1.
- R4: `svc_lvl` encodes 0 as idle and L+1 as serving level L. A maskable winner is presented only if L+1 > `svc_lvl`.
- R5: A pulse on `nmi_req` is latched and presented with vector 0 and `irq_lvl` 5. It takes precedence over every other request and is unaffected by enables or `svc_lvl`.
- R6: External edge mode per pin (2 bits at `ext_mode[2k+1:2k]`) behaves as follows: 00 ignores the pin, 01 latches on a rising edge, 10 latches on a falling edge, 11 latches on both edges. In unsampled mode the pin is evaluated on every clock.
- R7: With `ext_smp[k]` set, the pin is read only on cycles with `smp_tick` high. A level counts only after two consecutive ticks read the same value. A pulse seen by a single tick causes no request.
- R8: `swi_valid` with `swi_num` n latches a software request. It is presented with vector 64+n and `irq_lvl` equal to the current `svc_lvl`. It ranks below the non-maskable source and above all maskable sources, and it ignores the level rule.
- R9: `ack` while `irq_valid` clears the presented request's pending bit, pushes `svc_lvl` and sets `svc_lvl` to the `irq_lvl` that was presented.
- R10: `ret` pops the stack, so `svc_lvl` returns to the value it had before the matching `ack`.
- R11: A new request from a source that arrives in the same cycle as that source's `ack` stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| int_req | input | 29 | Internal maskable request strobes |
| ext_pin | input | 8 | External interrupt pins, synchronous to clk |
| smp_tick | input | 1 | Slow sample enable for filtered pins |
| nmi_req | input | 1 | Non-maskable request strobe |
| swi_valid | input | 1 | Software request strobe |
| swi_num | input | 6 | Software request number |
| src_en | input | 37 | Per-source enable |
| src_lvl | input | 74 | Per-source 2-bit priority, source i at [2i+1:2i] |
| ext_mode | input | 16 | Per-pin edge mode, pin k at [2k+1:2k] |
| ext_smp | input | 8 | Per-pin sample-filter enable |
| ack | input | 1 | Processor accepts presented request |
| ret | input | 1 | Processor returns from handler |
| irq_valid | output | 1 | A request is presented |
| irq_vec | output | 7 | Vector number of presented request |
| irq_lvl | output | 3 | Service level entered on acceptance |
| svc_lvl | output | 3 | Level currently in service |

## Verification
The checker assumes that the processor side follows the handshake. `ack` is raised only while `irq_valid` is high. `ret` is raised only while the level stack holds an entry. The two never coincide. Nesting never exceeds the stack depth. The bench pairs every `ack` with a later `ret` and nests at most three deep, which keeps within these rules. External pins are driven away from the clock edge, so they are already synchronous.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W  = 2;
  localparam int SVC_W  = 3;
  localparam int SWI_W  = 6;
  localparam int VEC_W  = SWI_W + 1;
  localparam logic [SVC_W-1:0] SVC_NMI = 3'd5;

  typedef logic [SVC_W-1:0] svc_t;
  typedef logic [VEC_W-1:0] vec_t;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_NMI  = 2'd1,
    K_SWI  = 2'd2,
    K_SRC  = 2'd3
  } win_kind_e;
endpackage

// File: rtl/irq_ext_filter.sv
module irq_ext_filter
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic       tick,
  input  logic       smp_en,
  input  edge_mode_e mode,
  output logic       hit
);
  logic lv_q, lv_d;
  logic prev_q, prev_d;
  logic rise, fall;

  // next state: filtered level and last sampled value
  always_comb begin
    lv_d   = lv_q;
    prev_d = prev_q;
    if (smp_en) begin
      if (tick) begin
        prev_d = pin;
        if (pin == prev_q) lv_d = pin;
      end
    end else begin
      prev_d = pin;
      lv_d   = pin;
    end
    rise = ~lv_q & lv_d;
    fall = lv_q & ~lv_d;
    unique case (mode)
      EDGE_OFF:  hit = 1'b0;
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      lv_q   <= lv_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_pkg::*;
#(
  parameter int NSRC  = 37,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]       pend,
  input  logic [NSRC-1:0]       en,
  input  logic [NSRC*LVL_W-1:0] lvl,
  input  svc_t                  svc,
  input  logic                  nmi_p,
  input  logic                  swi_p,
  input  logic [SWI_W-1:0]      swi_n,
  output logic                  valid,
  output win_kind_e             kind,
  output logic [IDX_W-1:0]      idx,
  output vec_t                  vec,
  output svc_t                  lvl_out
);
  logic             best_f;
  logic [LVL_W-1:0] best_l;
  logic [IDX_W-1:0] best_i;
  logic [LVL_W-1:0] cur_l;
  svc_t             best_svc;
  logic             src_ok;

  // ascending scan with strict compare: lowest index wins ties
  always_comb begin
    best_f = 1'b0;
    best_l = '0;
    best_i = '0;
    for (int i = 0; i < NSRC; i++) begin
      cur_l = lvl[i*LVL_W +: LVL_W];
      if (pend[i] && en[i] && (!best_f || cur_l > best_l)) begin
        best_f = 1'b1;
        best_l = cur_l;
        best_i = IDX_W'(i);
      end
    end
    best_svc = svc_t'(best_l) + svc_t'(1);
    src_ok   = best_f && (best_svc > svc);
  end

  always_comb begin
    valid   = 1'b0;
    kind    = K_NONE;
    idx     = '0;
    vec     = '0;
    lvl_out = '0;
    if (nmi_p) begin
      valid   = 1'b1;
      kind    = K_NMI;
      lvl_out = SVC_NMI;
    end else if (swi_p) begin
      valid   = 1'b1;
      kind    = K_SWI;
      vec     = {1'b1, swi_n};
      lvl_out = svc;
    end else if (src_ok) begin
      valid   = 1'b1;
      kind    = K_SRC;
      idx     = best_i;
      vec     = vec_t'(best_i) + vec_t'(1);
      lvl_out = best_svc;
    end
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  svc_t             push_val,
  output svc_t             cur,
  output logic [CNT_W-1:0] cnt
);
  svc_t             cur_q, cur_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  svc_t             mem_q [DEPTH];
  svc_t             top;
  logic             do_push, do_pop;

  always_comb begin
    top = '0;
    for (int e = 0; e < DEPTH; e++)
      if (cnt_q == CNT_W'(e + 1)) top = mem_q[e];
    do_push = push && (cnt_q != CNT_W'(DEPTH));
    do_pop  = pop && !push && (cnt_q != '0);
    cur_d = cur_q;
    cnt_d = cnt_q;
    if (do_push) begin
      cur_d = push_val;
      cnt_d = cnt_q + CNT_W'(1);
    end else if (do_pop) begin
      cur_d = top;
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      cnt_q <= '0;
    end else begin
      cur_q <= cur_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic wr;
    assign wr = do_push && (cnt_q == CNT_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[e] <= '0;
      else if (wr) mem_q[e] <= cur_q;
    end
  end

  assign cur = cur_q;
  assign cnt = cnt_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_INT     = 29,
  parameter int N_EXT     = 8,
  parameter int STK_DEPTH = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_INT-1:0]               int_req,
  input  logic [N_EXT-1:0]               ext_pin,
  input  logic                           smp_tick,
  input  logic                           nmi_req,
  input  logic                           swi_valid,
  input  logic [5:0]                     swi_num,
  input  logic [N_INT+N_EXT-1:0]         src_en,
  input  logic [2*(N_INT+N_EXT)-1:0]     src_lvl,
  input  logic [2*N_EXT-1:0]             ext_mode,
  input  logic [N_EXT-1:0]               ext_smp,
  input  logic                           ack,
  input  logic                           ret,
  output logic                           irq_valid,
  output logic [6:0]                     irq_vec,
  output logic [2:0]                     irq_lvl,
  output logic [2:0]                     svc_lvl
);
  localparam int NSRC  = N_INT + N_EXT;
  localparam int IDX_W = $clog2(NSRC);
  localparam int CNT_W = $clog2(STK_DEPTH + 1);

  logic [NSRC-1:0]  pend_q, pend_d, src_set, src_clr;
  logic             nmi_q, nmi_d;
  logic             swi_q, swi_d;
  logic [SWI_W-1:0] swin_q, swin_d;
  logic [N_EXT-1:0] ext_hit;
  logic             take;
  win_kind_e        kind;
  logic [IDX_W-1:0] win_idx;
  vec_t             win_vec;
  svc_t             win_lvl;
  svc_t             cur_svc;
  logic [CNT_W-1:0] stk_cnt;
  logic             win_valid;

  for (genvar k = 0; k < N_EXT; k++) begin : g_ext
    irq_ext_filter u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin    (ext_pin[k]),
      .tick   (smp_tick),
      .smp_en (ext_smp[k]),
      .mode   (edge_mode_e'(ext_mode[2*k +: 2])),
      .hit    (ext_hit[k])
    );
  end

  irq_arb #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .pend    (pend_q),
    .en      (src_en),
    .lvl     (src_lvl),
    .svc     (cur_svc),
    .nmi_p   (nmi_q),
    .swi_p   (swi_q),
    .swi_n   (swin_q),
    .valid   (win_valid),
    .kind    (kind),
    .idx     (win_idx),
    .vec     (win_vec),
    .lvl_out (win_lvl)
  );

  assign take = ack && win_valid;

  irq_lvl_stack #(.DEPTH(STK_DEPTH), .CNT_W(CNT_W)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (take),
    .pop      (ret),
    .push_val (win_lvl),
    .cur      (cur_svc),
    .cnt      (stk_cnt)
  );

  // next state of request latches; a new set outranks a same-cycle clear
  always_comb begin
    src_set = {ext_hit, int_req};
    src_clr = '0;
    if (take && kind == K_SRC) src_clr[win_idx] = 1'b1;
    pend_d = (pend_q & ~src_clr) | src_set;
    nmi_d  = (nmi_q & ~(take && kind == K_NMI)) | nmi_req;
    swi_d  = swi_q;
    swin_d = swin_q;
    if (take && kind == K_SWI) swi_d = 1'b0;
    if (swi_valid) begin
      swi_d  = 1'b1;
      swin_d = swi_num;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      nmi_q  <= 1'b0;
      swi_q  <= 1'b0;
      swin_q <= '0;
    end else begin
      pend_q <= pend_d;
      nmi_q  <= nmi_d;
      swi_q  <= swi_d;
      swin_q <= swin_d;
    end
  end

  assign irq_valid = win_valid;
  assign irq_vec   = win_vec;
  assign irq_lvl   = win_lvl;
  assign svc_lvl   = cur_svc;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             ret,
  input logic             irq_valid,
  input logic [6:0]       irq_vec,
  input logic [2:0]       irq_lvl,
  input logic [2:0]       svc_lvl,
  input logic [CNT_W-1:0] stk_cnt
);
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_vec == 7'd0 && irq_lvl == 3'd0));

  a_r5_nmi_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_vec == 7'd0) |-> irq_lvl == 3'd5);

  a_r4_above_svc: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_vec != 7'd0 && !irq_vec[6]) |-> irq_lvl > svc_lvl);

  a_r8_swi_keeps_lvl: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_vec[6]) |-> irq_lvl == svc_lvl);

  a_r9_ack_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_valid && stk_cnt != CNT_W'(DEPTH)) |=> svc_lvl == $past(irq_lvl));

  a_r10_ret_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ack && stk_cnt != '0) |=> svc_lvl <= $past(svc_lvl));

  // handshake rules on the processor side
  a_r9_ack_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> irq_valid);

  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    ret |-> stk_cnt != '0);

  a_r9_ack_ret_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && ret));
endmodule

bind irq_ctrl irq_ctrl_chk #(.DEPTH(STK_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack       (ack),
  .ret       (ret),
  .irq_valid (irq_valid),
  .irq_vec   (irq_vec),
  .irq_lvl   (irq_lvl),
  .svc_lvl   (svc_lvl),
  .stk_cnt   (stk_cnt)
);

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  logic        clk;
  logic        rst_n;
  logic [28:0] int_req;
  logic [7:0]  ext_pin;
  logic        smp_tick;
  logic        nmi_req;
  logic        swi_valid;
  logic [5:0]  swi_num;
  logic [36:0] src_en;
  logic [73:0] src_lvl;
  logic [15:0] ext_mode;
  logic [7:0]  ext_smp;
  logic        ack;
  logic        ret;
  logic        irq_valid;
  logic [6:0]  irq_vec;
  logic [2:0]  irq_lvl;
  logic [2:0]  svc_lvl;

  int checks = 0;
  int errors = 0;

  irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .int_req(int_req), .ext_pin(ext_pin),
    .smp_tick(smp_tick), .nmi_req(nmi_req), .swi_valid(swi_valid),
    .swi_num(swi_num), .src_en(src_en), .src_lvl(src_lvl),
    .ext_mode(ext_mode), .ext_smp(ext_smp), .ack(ack), .ret(ret),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
    .svc_lvl(svc_lvl)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_out(input string tag, input logic v,
                         input logic [6:0] vec, input logic [2:0] l);
    checks++;
    if (irq_valid !== v || (v && (irq_vec !== vec || irq_lvl !== l))) begin
      errors++;
      $display("FAIL %s: valid=%0b vec=%0d lvl=%0d expected valid=%0b vec=%0d lvl=%0d",
               tag, irq_valid, irq_vec, irq_lvl, v, vec, l);
    end
  endtask

  task automatic chk_svc(input string tag, input logic [2:0] exp);
    checks++;
    if (svc_lvl !== exp) begin
      errors++;
      $display("FAIL %s: svc_lvl=%0d expected %0d", tag, svc_lvl, exp);
    end
  endtask

  task automatic set_src(input int i, input logic en, input logic [1:0] l);
    src_en[i] = en;
    src_lvl[2*i +: 2] = l;
  endtask

  task automatic pulse_int(input int i);
    int_req[i] = 1'b1;
    step();
    int_req[i] = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  task automatic do_ret();
    ret = 1'b1;
    step();
    ret = 1'b0;
  endtask

  task automatic tick_once();
    smp_tick = 1'b1;
    step();
    smp_tick = 1'b0;
  endtask

  task automatic t_reset();
    chk_out("R1 reset output", 1'b0, 7'd0, 3'd0);
    chk_svc("R1 reset svc", 3'd0);
  endtask

  task automatic t_mask_latch();
    src_en = '0;
    pulse_int(5);
    chk_out("R2 disabled source hidden", 1'b0, 7'd0, 3'd0);
    set_src(5, 1'b1, 2'd0);
    step();
    chk_out("R2 enabled later presented", 1'b1, 7'd6, 3'd1);
    do_ack();
    chk_svc("R9 ack enters level", 3'd1);
    chk_out("R9 pending cleared", 1'b0, 7'd0, 3'd0);
    do_ret();
    chk_svc("R10 ret restores", 3'd0);
    chk_out("R9 nothing left", 1'b0, 7'd0, 3'd0);
  endtask

  task automatic t_priority();
    src_en = '0;
    set_src(3, 1'b1, 2'd1);
    set_src(10, 1'b1, 2'd2);
    set_src(20, 1'b1, 2'd2);
    int_req[3] = 1'b1; int_req[10] = 1'b1; int_req[20] = 1'b1;
    step();
    int_req = '0;
    chk_out("R3 high level, low index", 1'b1, 7'd11, 3'd3);
    do_ack();
    chk_out("R4 equal level blocked", 1'b0, 7'd0, 3'd0);
    do_ret();
    chk_out("R3 tie loser next", 1'b1, 7'd21, 3'd3);
    do_ack();
    do_ret();
    chk_out("R3 lowest level last", 1'b1, 7'd4, 3'd2);
    do_ack();
    do_ret();
    chk_out("R3 all served", 1'b0, 7'd0, 3'd0);
  endtask

  task automatic t_nest();
    src_en = '0;
    set_src(0, 1'b1, 2'd0);
    set_src(1, 1'b1, 2'd3);
    pulse_int(0);
    do_ack();
    chk_svc("R9 first level", 3'd1);
    pulse_int(1);
    chk_out("R4 higher level nests", 1'b1, 7'd2, 3'd4);
    do_ack();
    chk_svc("R9 nested level", 3'd4);
    do_ret();
    chk_svc("R10 back to outer", 3'd1);
    do_ret();
    chk_svc("R10 back to idle", 3'd0);
  endtask

  task automatic t_nmi();
    src_en = '0;
    set_src(2, 1'b1, 2'd3);
    pulse_int(2);
    do_ack();
    chk_svc("R5 setup top level", 3'd4);
    src_en = '0;
    nmi_req = 1'b1;
    step();
    nmi_req = 1'b0;
    chk_out("R5 nmi over top level", 1'b1, 7'd0, 3'd5);
    do_ack();
    chk_svc("R5 nmi level", 3'd5);
    chk_out("R5 nmi cleared", 1'b0, 7'd0, 3'd0);
    do_ret();
    chk_svc("R10 after nmi", 3'd4);
    do_ret();
    chk_svc("R10 idle after nmi", 3'd0);
  endtask

  task automatic t_swi();
    src_en = '0;
    set_src(4, 1'b1, 2'd1);
    int_req[4] = 1'b1; swi_valid = 1'b1; swi_num = 6'd9;
    step();
    int_req = '0; swi_valid = 1'b0;
    chk_out("R8 swi above maskable", 1'b1, 7'd73, 3'd0);
    do_ack();
    chk_svc("R8 swi keeps level", 3'd0);
    chk_out("R8 maskable after swi", 1'b1, 7'd5, 3'd2);
    do_ack();
    swi_valid = 1'b1; swi_num = 6'd63;
    step();
    swi_valid = 1'b0;
    chk_out("R8 swi ignores level", 1'b1, 7'd127, 3'd2);
    do_ack();
    chk_svc("R8 svc unchanged", 3'd2);
    do_ret();
    chk_svc("R10 pop swi", 3'd2);
    do_ret();
    chk_svc("R10 pop src", 3'd0);
    do_ret();
    chk_svc("R10 pop first swi", 3'd0);
    chk_out("R8 all served", 1'b0, 7'd0, 3'd0);
  endtask

  task automatic t_edge();
    src_en = '0;
    set_src(29, 1'b1, 2'd0);
    ext_mode[1:0] = 2'b01;
    ext_pin[0] = 1'b1; step();
    chk_out("R6 rise mode rise", 1'b1, 7'd30, 3'd1);
    do_ack(); do_ret();
    ext_pin[0] = 1'b0; step();
    chk_out("R6 rise mode fall", 1'b0, 7'd0, 3'd0);
    ext_mode[1:0] = 2'b10;
    ext_pin[0] = 1'b1; step();
    chk_out("R6 fall mode rise", 1'b0, 7'd0, 3'd0);
    ext_pin[0] = 1'b0; step();
    chk_out("R6 fall mode fall", 1'b1, 7'd30, 3'd1);
    do_ack(); do_ret();
    ext_mode[1:0] = 2'b11;
    ext_pin[0] = 1'b1; step();
    chk_out("R6 both mode rise", 1'b1, 7'd30, 3'd1);
    do_ack(); do_ret();
    ext_pin[0] = 1'b0; step();
    chk_out("R6 both mode fall", 1'b1, 7'd30, 3'd1);
    do_ack(); do_ret();
    ext_mode[1:0] = 2'b00;
    ext_pin[0] = 1'b1; step();
    ext_pin[0] = 1'b0; step();
    chk_out("R6 off mode ignores", 1'b0, 7'd0, 3'd0);
  endtask

  task automatic t_sample();
    src_en = '0;
    set_src(30, 1'b1, 2'd0);
    ext_mode[3:2] = 2'b01;
    ext_smp[1] = 1'b1;
    step();
    ext_pin[1] = 1'b1; tick_once();
    ext_pin[1] = 1'b0; tick_once();
    tick_once();
    chk_out("R7 single tick glitch dropped", 1'b0, 7'd0, 3'd0);
    ext_pin[1] = 1'b1;
    repeat (3) step();
    chk_out("R7 no tick no edge", 1'b0, 7'd0, 3'd0);
    tick_once();
    chk_out("R7 one tick not enough", 1'b0, 7'd0, 3'd0);
    tick_once();
    chk_out("R7 two ticks accepted", 1'b1, 7'd31, 3'd1);
    do_ack(); do_ret();
  endtask

  task automatic t_race();
    src_en = '0;
    set_src(7, 1'b1, 2'd0);
    pulse_int(7);
    chk_out("R11 presented", 1'b1, 7'd8, 3'd1);
    ack = 1'b1; int_req[7] = 1'b1;
    step();
    ack = 1'b0; int_req[7] = 1'b0;
    chk_svc("R11 level entered", 3'd1);
    chk_out("R11 masked by own level", 1'b0, 7'd0, 3'd0);
    do_ret();
    chk_out("R11 re-request kept", 1'b1, 7'd8, 3'd1);
    do_ack();
    do_ret();
    chk_out("R11 then cleared", 1'b0, 7'd0, 3'd0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    int_req = '0; ext_pin = '0; smp_tick = 1'b0; nmi_req = 1'b0;
    swi_valid = 1'b0; swi_num = '0; src_en = '0; src_lvl = '0;
    ext_mode = '0; ext_smp = '0; ack = 1'b0; ret = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_mask_latch();
    t_priority();
    t_nest();
    t_nmi();
    t_swi();
    t_edge();
    t_sample();
    t_race();
    summary();
    $finish;
  end
endmodule